// File: doc/BRIEF.md
# Driver Channel Fault Supervisor

This block watches over one low-side power driver channel. It takes the enable and input commands, a set of fault flags that are already digital and synchronous to the block clock, and, on a regulated channel, the measured output duty cycle in percent. It qualifies each flag against the switching state and requires the flag to persist for a window that depends on the fault class. It records accepted faults in an error register and catches protective faults in a shutdown latch that holds the power stage off. It drives a gate command and a status line.

The status line reports the switching state: low when off and high when on. While any error or shutdown is held, it reports the opposite level. Shutdown is cleared only by a genuinely long low command. A short low gap looks like PWM and leaves the channel latched off. All window lengths are cycle counts sampled from configuration ports in the first cycle after reset.

Top module: `chan_fault_sup`

## Requirements
- R1: Enable and input each pass through two flops. The switching state is their AND. Without faults, status_o is 1 when on and 0 when off. status_o and gate_o change three clock edges after an input change. Both are 0 in reset.
- R2: While the error register or the shutdown latch is set, status_o is the inverse of the switching state.
- R3: Short circuit (flt_i bit 0) and overtemperature (bit 1) are accepted only after being present on more than t_short consecutive edges. A gap restarts the count. Short circuit is evaluated only in the on state. Overtemperature is evaluated in both states.
- R4: Open load in the on state (bit 2), power-ground loss (bit 4), signal-ground loss (bit 5) and supply loss (bit 6) are accepted only after more than t_long consecutive edges.
- R5: Clock loss (bit 7) is accepted on its first edge, with no window.
- R6: After the last edge on which any fault is accepted, the error register stays set for t_hold further cycles. A single isolated pulse of L edges on a source with window W therefore inverts status for L-W-1+t_hold cycles when L>W, and for no cycles otherwise.
- R7: Accepted short circuit, overtemperature, clock loss or power-ground loss in the on state sets the shutdown latch. gate_o is the registered value of (switching state AND NOT shutdown).
- R8: The shutdown latch clears only after the switching state has been off on more than t_hold_reg consecutive edges (t_hold when REGULATED=0). A shorter low period leaves it set.
- R9: Short circuit, signal-ground loss and supply loss have no effect in the off state. Signal-ground and supply loss never set the shutdown latch.
- R10: Open load in the off state (bit 3) is evaluated only while the synchronized enable is high and the channel is off. With enable low it is ignored.
- R11: On a regulated channel in the on state, duty_i (a percentage) of 90 or more, or of 10 or less, is accepted after more than t_reg consecutive edges. It raises an error without setting the shutdown latch.
- R12: The timing ports are sampled once, in the first cycle after reset. Later changes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Channel enable command |
| in_i | input | 1 | Channel input / PWM command |
| flt_i | input | 8 | Digitized fault flags; bit map in R3–R5, R10 |
| duty_i | input | DUTY_W | Measured output duty in percent (regulated channel) |
| t_short_i | input | CNT_W | Short filter window, cycles |
| t_long_i | input | CNT_W | Long filter window, cycles |
| t_hold_i | input | CNT_W | Error hold and standard release time, cycles |
| t_hold_reg_i | input | CNT_W | Release time for a regulated channel, cycles |
| t_reg_i | input | CNT_W | Duty error window, cycles |
| gate_o | output | 1 | Registered power-stage gate command |
| status_o | output | 1 | Registered status line |

## Verification
The hardest condition to reach from the ports is the release boundary of the shutdown latch. It needs an accepted protective fault while the channel is on, followed by a low command of an exact length. The bench latches the channel with a filtered short circuit. It then sweeps the low gap from one cycle to past t_hold_reg and checks the gate after the input returns high. Filter windows are swept in the same way, by pulse length. The expected number of inverted status cycles for each length is computed from R6.

// File: rtl/chan_sup_pkg.sv
package chan_sup_pkg;

  localparam int unsigned NUM_FLT = 8;
  localparam int unsigned NUM_SRC = 10;

  // source indices; 0..7 match flt_i bits
  localparam int unsigned SRC_SHORT    = 0;
  localparam int unsigned SRC_OVERTEMP = 1;
  localparam int unsigned SRC_OPEN_ON  = 2;
  localparam int unsigned SRC_OPEN_OFF = 3;
  localparam int unsigned SRC_PGND     = 4;
  localparam int unsigned SRC_SGND     = 5;
  localparam int unsigned SRC_SUPPLY   = 6;
  localparam int unsigned SRC_CLK      = 7;
  localparam int unsigned SRC_DUTY_HI  = 8;
  localparam int unsigned SRC_DUTY_LO  = 9;

  typedef enum logic [1:0] {
    WIN_NONE,
    WIN_SHORT,
    WIN_LONG,
    WIN_REG
  } win_e;

  function automatic win_e src_window(int unsigned idx);
    case (idx)
      SRC_SHORT, SRC_OVERTEMP:              return WIN_SHORT;
      SRC_CLK:                              return WIN_NONE;
      SRC_DUTY_HI, SRC_DUTY_LO:             return WIN_REG;
      default:                              return WIN_LONG;
    endcase
  endfunction

  function automatic bit src_protective(int unsigned idx);
    return (idx == SRC_SHORT) || (idx == SRC_OVERTEMP) ||
           (idx == SRC_CLK)   || (idx == SRC_PGND);
  endfunction

endpackage

// File: rtl/chan_sup_sync.sv
module chan_sup_sync #(
  parameter int W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;

endmodule

// File: rtl/chan_sup_filter.sv
module chan_sup_filter #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             raw_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             hit_o
);

  logic [CNT_W-1:0] cnt_q;

  // counts consecutive raw edges, saturates at limit, restarts on a gap
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!raw_i)            cnt_q <= '0;
    else if (cnt_q < limit_i)   cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = raw_i && (cnt_q >= limit_i);

  AST_FILT_NEEDS_HISTORY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && (limit_i != '0)) |-> $past(raw_i)); // R3

endmodule

// File: rtl/chan_sup_hold.sv
module chan_sup_hold #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flag_i,
  input  logic [CNT_W-1:0] hold_i,
  output logic             held_o
);

  logic             held_q;
  logic [CNT_W-1:0] tmr_q;
  logic [CNT_W:0]   tmr_nxt;

  assign tmr_nxt = {1'b0, tmr_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      held_q <= 1'b0;
      tmr_q  <= '0;
    end else if (flag_i) begin
      held_q <= 1'b1;
      tmr_q  <= '0;
    end else if (held_q) begin
      if (tmr_nxt >= {1'b0, hold_i}) begin
        held_q <= 1'b0;
        tmr_q  <= '0;
      end else begin
        tmr_q  <= tmr_nxt[CNT_W-1:0];
      end
    end
  end

  assign held_o = held_q;

  AST_HOLD_TMR_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    held_q |-> ((tmr_q < hold_i) || (hold_i == '0))); // R6

  AST_HOLD_SET_ON_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flag_i |=> held_q); // R6

endmodule

// File: rtl/chan_sup_fail.sv
module chan_sup_fail #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             set_i,
  input  logic             on_i,
  input  logic [CNT_W-1:0] release_i,
  output logic             fail_o,
  output logic             fail_nxt_o
);

  logic             fail_q;
  logic [CNT_W-1:0] lo_q;
  logic             low_long;

  // length of the current low period, saturated at the release time
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 lo_q <= '0;
    else if (on_i)               lo_q <= '0;
    else if (lo_q < release_i)   lo_q <= lo_q + 1'b1;
  end

  assign low_long   = !on_i && (lo_q >= release_i);
  assign fail_nxt_o = set_i ? 1'b1 : (low_long ? 1'b0 : fail_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fail_q <= 1'b0;
    else         fail_q <= fail_nxt_o;
  end

  assign fail_o = fail_q;

  AST_FAIL_KEEP_WHILE_ON: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_q && on_i) |=> fail_q); // R8

  AST_FAIL_HAS_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(fail_q) |-> $past(set_i)); // R7

endmodule

// File: rtl/chan_fault_sup.sv
module chan_fault_sup
  import chan_sup_pkg::*;
#(
  parameter int CNT_W     = 8,
  parameter int DUTY_W    = 7,
  parameter bit REGULATED = 1'b1,
  parameter int HI_PCT    = 90,
  parameter int LO_PCT    = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                in_i,
  input  logic [NUM_FLT-1:0]  flt_i,
  input  logic [DUTY_W-1:0]   duty_i,
  input  logic [CNT_W-1:0]    t_short_i,
  input  logic [CNT_W-1:0]    t_long_i,
  input  logic [CNT_W-1:0]    t_hold_i,
  input  logic [CNT_W-1:0]    t_hold_reg_i,
  input  logic [CNT_W-1:0]    t_reg_i,
  output logic                gate_o,
  output logic                status_o
);

  // ---------------- configuration capture ----------------
  logic             cfg_vld_q;
  logic [CNT_W-1:0] tsf_q, tlf_q, thd_q, thr_q, tre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_vld_q <= 1'b0;
      tsf_q     <= '0;
      tlf_q     <= '0;
      thd_q     <= '0;
      thr_q     <= '0;
      tre_q     <= '0;
    end else if (!cfg_vld_q) begin
      cfg_vld_q <= 1'b1;
      tsf_q     <= t_short_i;
      tlf_q     <= t_long_i;
      thd_q     <= t_hold_i;
      thr_q     <= t_hold_reg_i;
      tre_q     <= t_reg_i;
    end
  end

  // ---------------- command synchronizer ----------------
  logic [1:0] cmd_s;
  logic       en_s, in_s, on_s;

  chan_sup_sync #(.W(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({en_i, in_i}),
    .q_o    (cmd_s)
  );

  assign en_s = cmd_s[1];
  assign in_s = cmd_s[0];
  assign on_s = en_s & in_s;

  // ---------------- duty comparison ----------------
  logic duty_hi, duty_lo;

  generate
    if (REGULATED) begin : g_reg
      assign duty_hi = duty_i >= DUTY_W'(HI_PCT);
      assign duty_lo = duty_i <= DUTY_W'(LO_PCT);
    end else begin : g_std
      assign duty_hi = 1'b0;
      assign duty_lo = 1'b0;
    end
  endgenerate

  // ---------------- state qualification ----------------
  logic [NUM_SRC-1:0] raw;

  always_comb begin
    raw               = '0;
    raw[SRC_SHORT]    = flt_i[SRC_SHORT]    & on_s;
    raw[SRC_OVERTEMP] = flt_i[SRC_OVERTEMP];
    raw[SRC_OPEN_ON]  = flt_i[SRC_OPEN_ON]  & on_s;
    raw[SRC_OPEN_OFF] = flt_i[SRC_OPEN_OFF] & ~on_s & en_s;
    raw[SRC_PGND]     = flt_i[SRC_PGND];
    raw[SRC_SGND]     = flt_i[SRC_SGND]     & on_s;
    raw[SRC_SUPPLY]   = flt_i[SRC_SUPPLY]   & on_s;
    raw[SRC_CLK]      = flt_i[SRC_CLK];
    raw[SRC_DUTY_HI]  = duty_hi & on_s;
    raw[SRC_DUTY_LO]  = duty_lo & on_s;
    if (!cfg_vld_q) raw = '0;
  end

  // ---------------- per-source filters ----------------
  logic [NUM_SRC-1:0] hit;
  logic [NUM_SRC-1:0] prot_hit;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    localparam win_e WIN = src_window(g);
    logic [CNT_W-1:0] lim;

    if (WIN == WIN_SHORT) begin : g_ws
      assign lim = tsf_q;
    end else if (WIN == WIN_LONG) begin : g_wl
      assign lim = tlf_q;
    end else if (WIN == WIN_REG) begin : g_wr
      assign lim = tre_q;
    end else begin : g_wn
      assign lim = '0;
    end

    chan_sup_filter #(.CNT_W(CNT_W)) u_filt (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .raw_i   (raw[g]),
      .limit_i (lim),
      .hit_o   (hit[g])
    );

    if (src_protective(g)) begin : g_prot
      assign prot_hit[g] = hit[g];
    end else begin : g_info
      assign prot_hit[g] = 1'b0;
    end
  end

  // ---------------- error register and shutdown latch ----------------
  logic             err_any, err_held;
  logic             fail_set, fail, fail_nxt;
  logic [CNT_W-1:0] release_t;

  assign err_any   = |hit;
  assign fail_set  = on_s & (|prot_hit);
  assign release_t = REGULATED ? thr_q : thd_q;

  chan_sup_hold #(.CNT_W(CNT_W)) u_hold (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .flag_i (err_any),
    .hold_i (thd_q),
    .held_o (err_held)
  );

  chan_sup_fail #(.CNT_W(CNT_W)) u_fail (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .set_i      (fail_set),
    .on_i       (on_s),
    .release_i  (release_t),
    .fail_o     (fail),
    .fail_nxt_o (fail_nxt)
  );

  // ---------------- outputs ----------------
  logic gate_q, status_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q   <= 1'b0;
      status_q <= 1'b0;
    end else begin
      gate_q   <= on_s & ~fail_nxt;
      status_q <= on_s ^ (err_held | fail);
    end
  end

  assign gate_o   = gate_q;
  assign status_o = status_q;

  AST_GATE_NOT_WHILE_FAIL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gate_o |-> !fail); // R7

  AST_INFO_NO_SHUTDOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_set) |-> (|(hit & ~(({NUM_SRC{1'b1}} << SRC_SGND) & ~({NUM_SRC{1'b1}} << (SRC_SUPPLY + 1)))))); // R9

  AST_GATE_OFF_WHEN_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !on_s |=> !gate_o); // R7

endmodule

// File: tb/chan_fault_sup_bench.sv
`timescale 1ns/1ps
module chan_fault_sup_bench;

  localparam int CNT_W  = 8;
  localparam int DUTY_W = 7;
  localparam int TSF = 3;
  localparam int TLF = 6;
  localparam int THD = 5;
  localparam int THR = 8;
  localparam int TRE = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, in = 1'b0;
  logic [7:0] flt = '0;
  logic [DUTY_W-1:0] duty = 7'd50;
  logic [CNT_W-1:0] c_sf = TSF, c_lf = TLF, c_hd = THD, c_hr = THR, c_re = TRE;
  logic gate, status;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  chan_fault_sup #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .REGULATED(1'b1)) u_chan_fault_sup (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .en_i         (en),
    .in_i         (in),
    .flt_i        (flt),
    .duty_i       (duty),
    .t_short_i    (c_sf),
    .t_long_i     (c_lf),
    .t_hold_i     (c_hd),
    .t_hold_reg_i (c_hr),
    .t_reg_i      (c_re),
    .gate_o       (gate),
    .status_o     (status)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_inv(input int len, input int win);
    return (len > win) ? (len - win - 1 + THD) : 0;
  endfunction

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic mode(input logic e, input logic i);
    @(negedge clk);
    en = e;
    in = i;
    wait_n(10);
  endtask

  // pulse one fault bit for len edges, count inverted status cycles and min gate
  task automatic pulse(input int b, input int len, output int inv, output int gmin);
    logic norm;
    norm = en & in;
    inv = 0;
    gmin = 1;
    @(negedge clk);
    flt[b] = 1'b1;
    for (int k = 0; k < len + THD + TLF + 15; k++) begin
      @(negedge clk);
      if (status !== norm) inv++;
      if (gate !== 1'b1) gmin = 0;
      if (k == len - 1) flt[b] = 1'b0;
    end
  endtask

  task automatic duty_hold(input int val, input int len, output int inv, output int gmin);
    inv = 0;
    gmin = 1;
    @(negedge clk);
    duty = DUTY_W'(val);
    for (int k = 0; k < len + THD + 15; k++) begin
      @(negedge clk);
      if (status !== 1'b1) inv++;
      if (gate !== 1'b1) gmin = 0;
      if (k == len - 1) duty = 7'd50;
    end
  endtask

  task automatic release_fail();
    @(negedge clk);
    in = 1'b0;
    wait_n(THR + 6);
  endtask

  initial begin
    int inv, gmin;
    wait_n(3);
    check(gate === 1'b0 && status === 1'b0, "R1 reset", {gate, status}, 0);
    rst_n = 1'b1;
    wait_n(3);
    // R12: later changes on the timing ports must be ignored
    c_sf = 8'd30; c_lf = 8'd30; c_hd = 8'd30; c_hr = 8'd30; c_re = 8'd30;
    wait_n(3);
    check(status === 1'b0, "R1 idle off", status, 0);

    // R1 latency: three edges from command to outputs
    @(negedge clk);
    en = 1'b1; in = 1'b1;
    wait_n(2);
    check(status === 1'b0, "R1 latency before", status, 0);
    wait_n(1);
    check(status === 1'b1 && gate === 1'b1, "R1 latency on", {status, gate}, 3);
    @(negedge clk);
    in = 1'b0;
    wait_n(2);
    check(gate === 1'b1, "R1 latency hold", gate, 1);
    wait_n(1);
    check(status === 1'b0 && gate === 1'b0, "R1 off", {status, gate}, 0);

    // R3: overtemperature in off state, length sweep
    mode(1'b0, 1'b0);
    for (int len = 1; len <= TSF + 3; len++) begin
      pulse(1, len, inv, gmin);
      check(inv == exp_inv(len, TSF), "R3 R6 overtemp window", inv, exp_inv(len, TSF));
    end
    pulse(1, TSF + 1, inv, gmin);
    check(inv == THD, "R12 captured short window", inv, THD);

    // R3: gap restarts the filter
    @(negedge clk);
    flt[1] = 1'b1;
    wait_n(TSF);
    flt[1] = 1'b0;
    wait_n(1);
    flt[1] = 1'b1;
    wait_n(TSF);
    flt[1] = 1'b0;
    inv = 0;
    for (int k = 0; k < THD + 10; k++) begin
      @(negedge clk);
      if (status !== 1'b0) inv++;
    end
    check(inv == 0, "R3 gap restart", inv, 0);

    // R4: power-ground loss in off state, length sweep
    for (int len = 1; len <= TLF + 2; len++) begin
      pulse(4, len, inv, gmin);
      check(inv == exp_inv(len, TLF), "R4 R6 pgnd window", inv, exp_inv(len, TLF));
    end

    // R9: short, signal-ground and supply loss ignored when off
    pulse(0, TLF + 4, inv, gmin);
    check(inv == 0, "R9 short ignored off", inv, 0);
    pulse(5, TLF + 4, inv, gmin);
    check(inv == 0, "R9 sgnd ignored off", inv, 0);
    pulse(6, TLF + 4, inv, gmin);
    check(inv == 0, "R9 supply ignored off", inv, 0);

    // R5: clock loss unfiltered
    pulse(7, 1, inv, gmin);
    check(inv == THD, "R5 clock single edge", inv, THD);
    pulse(7, 2, inv, gmin);
    check(inv == THD + 1, "R5 clock two edges", inv, THD + 1);

    // R10: off-state open load needs enable
    pulse(3, TLF + 2, inv, gmin);
    check(inv == 0, "R10 open-off ignored en low", inv, 0);
    mode(1'b1, 1'b0);
    pulse(3, TLF + 2, inv, gmin);
    check(inv == exp_inv(TLF + 2, TLF), "R10 open-off detected", inv, exp_inv(TLF + 2, TLF));

    // on state: R2 inversion, R4 open-on, R9 info faults keep gate
    mode(1'b1, 1'b1);
    pulse(3, TLF + 2, inv, gmin);
    check(inv == 0, "R10 open-off ignored when on", inv, 0);
    pulse(2, TLF + 1, inv, gmin);
    check(inv == THD, "R2 R4 open-on inverted", inv, THD);
    pulse(5, TLF + 3, inv, gmin);
    check(inv == THD + 2, "R9 sgnd on", inv, THD + 2);
    check(gmin == 1, "R9 sgnd no shutdown", gmin, 1);
    pulse(6, TLF + 3, inv, gmin);
    check(inv == THD + 2, "R9 supply on", inv, THD + 2);
    check(gmin == 1, "R9 supply no shutdown", gmin, 1);

    // R11: duty thresholds
    begin
      int vals[7] = '{5, 10, 11, 50, 89, 90, 95};
      for (int j = 0; j < 7; j++) begin
        int e;
        e = (vals[j] >= 90 || vals[j] <= 10) ? exp_inv(TRE + 3, TRE) : 0;
        duty_hold(vals[j], TRE + 3, inv, gmin);
        check(inv == e, "R11 duty threshold", inv, e);
        check(gmin == 1, "R11 duty no shutdown", gmin, 1);
      end
    end
    for (int len = 1; len <= TRE + 2; len++) begin
      duty_hold(95, len, inv, gmin);
      check(inv == exp_inv(len, TRE), "R11 duty window", inv, exp_inv(len, TRE));
    end

    // R7/R8: shutdown via short circuit, release gap sweep
    for (int p = 1; p <= THR + 2; p++) begin
      mode(1'b1, 1'b1);
      @(negedge clk);
      flt[0] = 1'b1;
      wait_n(TSF + 2);
      flt[0] = 1'b0;
      wait_n(3);
      check(gate === 1'b0, "R7 short shutdown", gate, 0);
      check(status === 1'b0, "R2 status while latched", status, 0);
      wait_n(THD + 5);
      check(gate === 1'b0 && status === 1'b0, "R7 latch holds", {gate, status}, 0);
      @(negedge clk);
      in = 1'b0;
      wait_n(p);
      in = 1'b1;
      wait_n(THD + 10);
      check(gate === (p > THR), "R8 release gap", gate, (p > THR));
      release_fail();
    end

    // R7: other protective sources in on state
    begin
      int srcs[3] = '{1, 4, 7};
      int lens[3] = '{TSF + 2, TLF + 2, 1};
      for (int j = 0; j < 3; j++) begin
        mode(1'b1, 1'b1);
        @(negedge clk);
        flt[srcs[j]] = 1'b1;
        wait_n(lens[j]);
        flt[srcs[j]] = 1'b0;
        wait_n(THD + 5);
        check(gate === 1'b0, "R7 protective source", gate, 0);
        release_fail();
      end
    end
    mode(1'b1, 1'b1);
    check(gate === 1'b1 && status === 1'b1, "R8 released on", {gate, status}, 3);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule